// File: doc/BRIEF.md
# Flash Buffered-Write Host Sequencer

This block sits on the host side of a parallel NOR-style flash command bus. It programs up to one write buffer of data per request. A request carries a block address, a start address and an encoded count N, where N+1 data words follow. The data words arrive on a separate valid/ready stream. The sequencer then drives the chip-enable, write-enable and output-enable strobes through the full buffered-program handshake.

The handshake runs as follows. The sequencer writes the buffer-request command and reads back the extended status. It repeats that pair until a buffer is free or a retry limit runs out. It then writes the count, the data words and the confirm command. After that it reads status until the internal program engine reports ready. Finally it writes the read-array command. Each request ends in exactly one single-cycle result pulse, which is done, time-out or range error. A new request may be accepted on the cycle after the result pulse.

Top module: `fbw_seq`

## Requirements
- R1: After a request is accepted with a legal range, the first bus operation is a write of 0xE8 to the block base, which is the block address with its low BLK_W bits cleared. All command writes and status reads use that base.
- R2: Each 0xE8 write is followed by one status read. If bit 7 of the read data is 1, the sequencer moves on. If it is 0, another 0xE8 write and another read follow.
- R3: If POLL_LIMIT consecutive status reads see bit 7 at 0, err_timeout pulses for one cycle. The pulse comes on the cycle after the last of those reads. No count, data or confirm write is made.
- R4: Once a buffer is free, the next operation is a write of the encoded count N, zero-extended, to the block base.
- R5: Exactly N+1 data writes follow. Write x goes to address start+x and carries the x-th word of the stream, in order. dat_ready is asserted only together with dat_valid, and only in the cycle that launches a data write.
- R6: After the last data write, the sequencer writes 0xD0 to the block base.
- R7: After the 0xD0 write, status reads repeat until one returns bit 7 set.
- R8: The ready status read is followed by a write of 0xFF to the block base. done pulses for one cycle, on the cycle after that write's strobes end. At most one of done, err_timeout and err_range is high in any cycle.
- R9: A request is rejected when its start address lies in a different block, or when start offset + N exceeds 2^BLK_W-1. err_range then pulses on the cycle after acceptance, and no bus operation is made. A range that ends exactly on the last word of the block is accepted.
- R10: A write holds bus_ce_n and bus_we_n low for exactly WE_CYC cycles. A read holds bus_ce_n and bus_oe_n low for exactly OE_LAT cycles, and bus_rdata is sampled in the last of them. Address and data stay stable while the strobes are low. At least one cycle with bus_ce_n high separates operations, and bus_we_n and bus_oe_n are never low together.
- R11: req_ready is high only while the sequencer is idle, and bus_ce_n is high whenever req_ready is high. A new request is accepted on the first cycle after a result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_block | input | AW | Target block address (low BLK_W bits ignored) |
| req_start | input | AW | Address of the first data word |
| req_count | input | CW | Encoded count N; N+1 words follow |
| dat_valid | input | 1 | Data word present |
| dat_ready | output | 1 | Data word taken this cycle |
| dat_data | input | DW | Data word |
| bus_ce_n | output | 1 | Flash chip enable, active low |
| bus_we_n | output | 1 | Flash write enable, active low |
| bus_oe_n | output | 1 | Flash output enable, active low |
| bus_addr | output | AW | Flash address |
| bus_wdata | output | DW | Flash write data |
| bus_rdata | input | DW | Flash read data |
| done | output | 1 | One-cycle pulse: program sequence finished |
| err_timeout | output | 1 | One-cycle pulse: no buffer became free in time |
| err_range | output | 1 | One-cycle pulse: request range crosses the block |

## Verification
Every result is tied to a fixed cycle. err_range is due one cycle after the accepting edge. done and err_timeout are due in the first cycle with bus_ce_n high after the final write or read of their sequence. Each bus operation is judged when its strobes rise, from the count of low cycles seen at falling clock edges. The reference model lists the expected operations per request and compares each completed one with the head of that list. On every falling edge it also compares all three result flags with what the model expects in that exact cycle, so a pulse that arrives early, late or not at all is reported.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

  localparam logic [7:0] CMD_BUF_REQ   = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
  localparam logic [7:0] CMD_ARRAY_MODE = 8'hFF;
  localparam int         RDY_BIT       = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XSTAT,
    ST_COUNT,
    ST_DATA,
    ST_CONFIRM,
    ST_POLL,
    ST_ARRAY
  } seq_state_e;

endpackage

// File: rtl/fbw_range_chk.sv
module fbw_range_chk #(
  parameter int AW    = 24,
  parameter int BLK_W = 16,
  parameter int CW    = 4
) (
  input  logic [AW-1:0] block_addr,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] count_m1,
  output logic          range_ok
);

  logic          same_blk;
  logic [BLK_W:0] end_off;

  always_comb begin
    same_blk = (start_addr[AW-1:BLK_W] == block_addr[AW-1:BLK_W]);
    end_off  = {1'b0, start_addr[BLK_W-1:0]} + (BLK_W+1)'(count_m1);
    range_ok = same_blk && !end_off[BLK_W];
  end

endmodule

// File: rtl/fbw_retry_timer.sv
module fbw_retry_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic expired
);

  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_n  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign expired = (cnt_q == TW'(LIMIT - 1));

endmodule

// File: rtl/fbw_bus_phy.sv
module fbw_bus_phy #(
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int WE_CYC = 3,
  parameter int OE_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          op_done,
  output logic          bus_ce_n,
  output logic          bus_we_n,
  output logic          bus_oe_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata
);

  localparam int MAXC = (WE_CYC > OE_LAT) ? WE_CYC : OE_LAT;
  localparam int LW   = $clog2(MAXC + 1);

  logic          act_q, act_n;
  logic          wr_q;
  logic [LW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          load;

  always_comb begin
    load  = start && !act_q;
    act_n = act_q;
    cnt_n = cnt_q;
    if (load) begin
      act_n = 1'b1;
      cnt_n = is_wr ? LW'(WE_CYC - 1) : LW'(OE_LAT - 1);
    end else if (act_q) begin
      if (cnt_q == '0) act_n = 1'b0;
      else             cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      wr_q   <= is_wr;
      addr_q <= addr;
      data_q <= is_wr ? wdata : '0;
    end
  end

  assign op_done   = act_q && (cnt_q == '0);
  assign bus_ce_n  = !act_q;
  assign bus_we_n  = !(act_q && wr_q);
  assign bus_oe_n  = !(act_q && !wr_q);
  assign bus_addr  = addr_q;
  assign bus_wdata = data_q;

  assert_gap_after_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> bus_ce_n);
  assert_strobe_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ce_n && !op_done) |=> (!bus_ce_n && $stable(bus_addr) && $stable(bus_we_n)));
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_we_n && !bus_oe_n));

endmodule

// File: rtl/fbw_seq.sv
module fbw_seq
  import fbw_pkg::*;
#(
  parameter int AW         = 24,
  parameter int DW         = 16,
  parameter int BLK_W      = 16,
  parameter int BUF_WORDS  = 16,
  parameter int WE_CYC     = 3,
  parameter int OE_LAT     = 2,
  parameter int POLL_LIMIT = 1000,
  localparam int CW        = $clog2(BUF_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_block,
  input  logic [AW-1:0] req_start,
  input  logic [CW-1:0] req_count,
  input  logic          dat_valid,
  output logic          dat_ready,
  input  logic [DW-1:0] dat_data,
  output logic          bus_ce_n,
  output logic          bus_we_n,
  output logic          bus_oe_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic          err_timeout,
  output logic          err_range
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  seq_state_e    state_q, state_n;
  logic          launched_q, launched_n;
  logic [AW-1:0] base_q, start_q;
  logic [CW-1:0] n_q, x_q, x_n;
  logic          done_q, done_n, to_q, to_n, rng_q, rng_n;
  logic          take_req, range_ok;
  logic          go, op_wr, phy_done, tmr_clr, tmr_inc, tmr_exp, rdy;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;

  fbw_range_chk #(.AW(AW), .BLK_W(BLK_W), .CW(CW)) u_rchk (
    .block_addr (req_block),
    .start_addr (req_start),
    .count_m1   (req_count),
    .range_ok   (range_ok)
  );

  fbw_retry_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .clr     (tmr_clr),
    .inc     (tmr_inc),
    .expired (tmr_exp)
  );

  fbw_bus_phy #(.AW(AW), .DW(DW), .WE_CYC(WE_CYC), .OE_LAT(OE_LAT)) u_phy (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start     (go),
    .is_wr     (op_wr),
    .addr      (op_addr),
    .wdata     (op_data),
    .op_done   (phy_done),
    .bus_ce_n  (bus_ce_n),
    .bus_we_n  (bus_we_n),
    .bus_oe_n  (bus_oe_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
  );

  assign rdy       = bus_rdata[RDY_BIT];
  assign req_ready = (state_q == ST_IDLE);
  assign take_req  = req_ready && req_valid;

  always_comb begin
    state_n    = state_q;
    x_n        = x_q;
    done_n     = 1'b0;
    to_n       = 1'b0;
    rng_n      = 1'b0;
    tmr_clr    = 1'b0;
    tmr_inc    = 1'b0;
    op_wr      = 1'b1;
    op_addr    = base_q;
    op_data    = '0;
    go         = (state_q != ST_IDLE) && !launched_q &&
                 ((state_q != ST_DATA) || dat_valid);
    case (state_q)
      ST_IDLE: begin
        if (take_req) begin
          if (range_ok) begin
            state_n = ST_SETUP;
            tmr_clr = 1'b1;
          end else begin
            rng_n = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        op_data = DW'(CMD_BUF_REQ);
        if (phy_done) state_n = ST_XSTAT;
      end
      ST_XSTAT: begin
        op_wr = 1'b0;
        if (phy_done) begin
          if (rdy) begin
            state_n = ST_COUNT;
          end else if (tmr_exp) begin
            to_n    = 1'b1;
            state_n = ST_IDLE;
          end else begin
            tmr_inc = 1'b1;
            state_n = ST_SETUP;
          end
        end
      end
      ST_COUNT: begin
        op_data = DW'(n_q);
        if (phy_done) begin
          x_n     = '0;
          state_n = ST_DATA;
        end
      end
      ST_DATA: begin
        op_addr = start_q + AW'(x_q);
        op_data = dat_data;
        if (phy_done) begin
          if (x_q == n_q) state_n = ST_CONFIRM;
          else            x_n     = x_q + 1'b1;
        end
      end
      ST_CONFIRM: begin
        op_data = DW'(CMD_CONFIRM);
        if (phy_done) state_n = ST_POLL;
      end
      ST_POLL: begin
        op_wr = 1'b0;
        if (phy_done && rdy) state_n = ST_ARRAY;
      end
      ST_ARRAY: begin
        op_data = DW'(CMD_ARRAY_MODE);
        if (phy_done) begin
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
    if (phy_done)  launched_n = 1'b0;
    else if (go)   launched_n = 1'b1;
    else           launched_n = launched_q;
  end

  assign dat_ready = go && (state_q == ST_DATA);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q    <= ST_IDLE;
      launched_q <= 1'b0;
      x_q        <= '0;
      done_q     <= 1'b0;
      to_q       <= 1'b0;
      rng_q      <= 1'b0;
    end else begin
      state_q    <= state_n;
      launched_q <= launched_n;
      x_q        <= x_n;
      done_q     <= done_n;
      to_q       <= to_n;
      rng_q      <= rng_n;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      base_q  <= '0;
      start_q <= '0;
      n_q     <= '0;
    end else if (take_req) begin
      base_q  <= {req_block[AW-1:BLK_W], {BLK_W{1'b0}}};
      start_q <= req_start;
      n_q     <= req_count;
    end
  end

  assign done        = done_q;
  assign err_timeout = to_q;
  assign err_range   = rng_q;

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_ready |-> bus_ce_n);
  assert_single_result_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({done, err_timeout, err_range}));
  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |-> $past(!bus_we_n));
  assert_take_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    dat_ready |-> dat_valid);
  assert_reject_no_bus_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_range |-> (bus_ce_n && $past(req_valid)));
  assert_timeout_after_read_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_timeout |-> $past(!bus_oe_n));

endmodule

// File: tb/sim_fbw_seq.sv
module sim_fbw_seq;

  localparam int AW = 16, DW = 16, BLK_W = 6, BUF_WORDS = 16;
  localparam int WE_CYC = 2, OE_LAT = 3, POLL_LIMIT = 4;
  localparam int CW = $clog2(BUF_WORDS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_block = '0, req_start = '0;
  logic [CW-1:0] req_count = '0;
  logic dat_valid = 1'b0, dat_ready;
  logic [DW-1:0] dat_data = '0;
  logic bus_ce_n, bus_we_n, bus_oe_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic done, err_timeout, err_range;

  always #5 clk = ~clk;

  fbw_seq #(.AW(AW), .DW(DW), .BLK_W(BLK_W), .BUF_WORDS(BUF_WORDS), .WE_CYC(WE_CYC),
            .OE_LAT(OE_LAT), .POLL_LIMIT(POLL_LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_block(req_block), .req_start(req_start), .req_count(req_count),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data),
    .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .err_timeout(err_timeout), .err_range(err_range));

  int total = 0, bad = 0;

  // expected bus operations
  int    ex_wr[$], ex_addr[$], ex_data[$], ex_ev[$], ex_cue[$];
  string ex_tag[$];
  int    xs_q[$], sr_q[$];
  int    dat_arr[$];
  int    dat_idx = 0;
  int    cyc = 0;
  bit    stall_en = 1'b0;
  bit    req_bad = 1'b0;
  bit    acc_bad_q = 1'b0;
  int    rng_seen = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void ex(input int wr, input int a, input int d, input int ev,
                             input int cue, input string tag);
    ex_wr.push_back(wr); ex_addr.push_back(a); ex_data.push_back(d);
    ex_ev.push_back(ev); ex_cue.push_back(cue); ex_tag.push_back(tag);
  endfunction

  always @(posedge clk) begin
    cyc++;
    acc_bad_q <= req_valid && req_ready && req_bad;
    if (dat_valid && dat_ready) dat_idx++;
  end

  always @(negedge clk) begin
    dat_valid <= (dat_idx < dat_arr.size()) && !(stall_en && cyc[0]);
    dat_data  <= (dat_idx < dat_arr.size()) ? DW'(dat_arr[dat_idx]) : '0;
  end

  // bus monitor, flash response model and per-cycle flag comparison
  int  run = 0;
  bit  m_wr;
  int  m_addr, m_data;
  always @(negedge clk) begin
    bit exp_d, exp_t;
    exp_d = 1'b0; exp_t = 1'b0;
    if (rst_n) begin
      if (!bus_ce_n) begin
        if (run == 0) begin
          m_wr = !bus_we_n; m_addr = int'(bus_addr); m_data = int'(bus_wdata);
        end
        run++;
      end else if (run > 0) begin
        if (ex_wr.size() == 0) begin
          chk(1'b0, "R9", "unexpected bus op addr", m_addr, -1);
        end else begin
          int w, a, d, ev, cue; string tg;
          w = ex_wr.pop_front(); a = ex_addr.pop_front(); d = ex_data.pop_front();
          ev = ex_ev.pop_front(); cue = ex_cue.pop_front(); tg = ex_tag.pop_front();
          chk(int'(m_wr) == w, tg, "op is write", int'(m_wr), w);
          chk(m_addr == a, tg, "address", m_addr, a);
          if (w == 1) chk(m_data == d, tg, "write data", m_data, d);
          chk(run == (m_wr ? WE_CYC : OE_LAT), "R10", "strobe cycles", run,
              m_wr ? WE_CYC : OE_LAT);
          exp_d = (ev == 1); exp_t = (ev == 2);
          if (cue == 1) bus_rdata = DW'(xs_q.size() ? xs_q.pop_front() : 0);
          if (cue == 2 || (w == 0 && cue == 3))
            bus_rdata = DW'(sr_q.size() ? sr_q.pop_front() : 8'h80);
        end
        run = 0;
      end
      if (done || exp_d) chk(done == exp_d, "R8", "done pulse", done, exp_d);
      if (err_timeout || exp_t) chk(err_timeout == exp_t, "R3", "timeout pulse", err_timeout, exp_t);
      if (err_range || acc_bad_q) begin
        chk(err_range == acc_bad_q, "R9", "range pulse", err_range, acc_bad_q);
        if (err_range) rng_seen++;
      end
      if (req_ready && !bus_ce_n) chk(1'b0, "R11", "ce_n while idle", bus_ce_n, 1);
      if (!bus_we_n && !bus_oe_n) chk(1'b0, "R10", "we_n/oe_n overlap", 0, 1);
    end
  end

  task automatic issue(input int blk, input int st, input int n, input bit badr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_block = AW'(blk); req_start = AW'(st);
    req_count = CW'(n); req_bad = badr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // plan a successful request: nb busy buffer answers, ns busy status answers
  task automatic plan_ok(input int blk, input int st, input int n, input int nb, input int ns,
                         input int dbase);
    int base;
    base = blk & ~((1 << BLK_W) - 1);
    for (int i = 0; i < nb; i++) xs_q.push_back(8'h00);
    xs_q.push_back(8'h80);
    for (int i = 0; i <= nb; i++) begin
      ex(1, base, 8'hE8, 0, 1, "R1");
      ex(0, base, 0, 0, 0, "R2");
    end
    ex(1, base, n, 0, 0, "R4");
    for (int i = 0; i <= n; i++) begin
      dat_arr.push_back((dbase + i * 16'h0123) & 16'hFFFF);
      ex(1, st + i, (dbase + i * 16'h0123) & 16'hFFFF, 0, 0, "R5");
    end
    ex(1, base, 8'hD0, 0, 2, "R6");
    for (int i = 0; i < ns; i++) sr_q.push_back(8'h01);
    sr_q.push_back(8'h80);
    for (int i = 0; i <= ns; i++) ex(0, base, 0, 0, 3, "R7");
    ex(1, base, 8'hFF, 1, 0, "R8");
  endtask

  task automatic drain();
    while (ex_wr.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R11", "reset req_ready", req_ready, 1);
    chk(bus_ce_n && bus_we_n && bus_oe_n, "R10", "reset strobes high", bus_ce_n, 1);
    chk(!done && !err_timeout && !err_range, "R8", "reset results low", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // basic: block address with low bits set, buffer free at once, two busy polls
    plan_ok(16'h0145, 16'h0144, 3, 0, 2, 16'h1000);
    issue(16'h0145, 16'h0144, 3, 1'b0);
    drain();

    // two busy buffer answers then free, single word, back to back
    plan_ok(16'h0200, 16'h0210, 0, 2, 0, 16'h2222);
    issue(16'h0200, 16'h0210, 0, 1'b0);
    drain();

    // full buffer with a stalling data source
    stall_en = 1'b1;
    plan_ok(16'h0300, 16'h0300, 15, 1, 1, 16'h3333);
    issue(16'h0300, 16'h0300, 15, 1'b0);
    drain();
    stall_en = 1'b0;

    // range ending on the last word of the block is legal (R9 boundary)
    plan_ok(16'h0400, 16'h043C, 3, 0, 0, 16'h4444);
    issue(16'h0400, 16'h043C, 3, 1'b0);
    drain();
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1, "R11", "idle after done", req_ready, 1);

    // time-out: buffer never free
    for (int i = 0; i < POLL_LIMIT; i++) begin
      xs_q.push_back(8'h00);
      ex(1, 16'h0500, 8'hE8, 0, 1, "R3");
      ex(0, 16'h0500, 0, (i == POLL_LIMIT - 1) ? 2 : 0, 0, "R3");
    end
    issue(16'h0500, 16'h0500, 2, 1'b0);
    drain();
    repeat (10) @(negedge clk);
    chk(dat_idx == dat_arr.size(), "R3", "no data taken", dat_idx, dat_arr.size());

    // range errors: crossing the block end, and start in another block
    issue(16'h0600, 16'h063D, 3, 1'b1);
    repeat (10) @(negedge clk);
    issue(16'h0600, 16'h0700, 0, 1'b1);
    repeat (10) @(negedge clk);
    chk(rng_seen == 2, "R9", "range pulses", rng_seen, 2);

    // after rejection a legal request still runs
    plan_ok(16'h0700, 16'h0701, 1, 0, 0, 16'h7777);
    issue(16'h0700, 16'h0701, 1, 1'b0);
    drain();
    repeat (4) @(negedge clk);
    chk(dat_idx == dat_arr.size(), "R5", "all words taken", dat_idx, dat_arr.size());

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule